// File: doc/BRIEF.md
# Tap-Selectable Serial Clock Divider

This block produces the one clock that a serial controller uses for both its transmitter and its receiver. The clock is derived from a slow reference strobe (one system-clock-wide pulse at 307.2 kHz in the intended setting: 18.432 MHz divided by 60). Each reference strobe advances a free-running 8-bit counter. A one-hot rate-select input chooses which counter bits are watched.

Whenever a watched bit changes on a strobe, an event fires. On each event the output presents the level held in a two-state machine, and that machine then moves to its other state. Transmit and receive are fed from the same output, so they always share one rate. With a single select bit `b`, an event fires every 2^b strobes. The resulting serial clock period is 2^(b+1) strobes.

The select codes map to rates as follows: 0x40 gives 75 baud, 0x20 gives 150, 0x10 gives 300, 0x08 gives 600, 0x04 gives 1200, 0x02 gives 2400 and 0x01 gives 4800. A tie-off of 0x01 is the usual power-on choice.

The level machine has two states:
- `LVL_LO` moves to `LVL_HI` on an event and otherwise stays.
- `LVL_HI` moves to `LVL_LO` on an event and otherwise stays.

Top module: `tap_serial_clkgen`

## Requirements
- R1: While `rst` is high on a clock edge, the counter clears to 0, the level machine enters `LVL_LO`, and `ser_clk` and `edge_stb` are 0 after that edge.
- R2: A clock edge with `ref_tick` low leaves the counter unchanged and produces no event: `edge_stb` is 0 after it and `ser_clk` holds.
- R3: With `rate_sel` = 1<<b, an event fires on exactly those strobes whose incremented counter value is a multiple of 2^b. Bit 0 (code 0x01) therefore fires on every strobe.
- R4: On an event, `ser_clk` takes the level of the state held before the event (`LVL_LO` gives 0, `LVL_HI` gives 1), and the state then flips. Outside events, `ser_clk` does not change.
- R5: `edge_stb` is high for exactly the one cycle after the edge that registered an event, and low otherwise.
- R6: `rate_sel` is 7 bits wide; bit 6 (code 0x40) fires every 64 strobes.
- R7: With several select bits set, one event fires on any strobe where at least one selected bit changes. When several selected bits change on the same strobe, only one event fires.
- R8: The counter wraps from 0xFF to 0x00, and every selected bit registers its change across the wrap.
- R9: A change of `rate_sel` applies to the very next strobe, with no history carried over from the earlier setting.
- R10: With `rate_sel` = 0, no event ever fires, although the counter keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference strobe; advances the counter when high |
| rate_sel | input | 7 | One-hot tap choice (0x01..0x40) |
| ser_clk | output | 1 | Shared transmit/receive serial clock level |
| edge_stb | output | 1 | One-cycle pulse marking each output update |

## Verification
Counter wrap and select-bit transitions can land on the same strobe. At 0xFF to 0x00, every selected bit flips at once. The sweep with all seven bits selected drives the counter through several wraps. The bench model expects exactly one level change per such strobe, not one per flipping bit. Select changes are also made on the strobe just before a wrap, so that the new mask and the wrap take effect in the same cycle.

// File: rtl/tap_clkgen_pkg.sv
package tap_clkgen_pkg;

    // Level held by the output machine; presented on the next event.
    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

endpackage

// File: rtl/tap_ref_counter.sv
module tap_ref_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx
);

    // Incremented value; natural modulo wrap at 2^CNT_W.
    assign cnt_nx = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_nx;
        end
    end

endmodule

// File: rtl/tap_transition_sel.sv
module tap_transition_sel #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 7
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] nxt,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] flips;

    // Widen the select to counter width; untapped upper bits never fire.
    generate
        if (SEL_W < CNT_W) begin : g_pad
            assign mask = {{(CNT_W-SEL_W){1'b0}}, sel};
        end else begin : g_full
            assign mask = sel[CNT_W-1:0];
        end
    endgenerate

    assign flips = (cur ^ nxt) & mask;
    assign hit   = |flips;

endmodule

// File: rtl/tap_level_fsm.sv
module tap_level_fsm
    import tap_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ser_clk,
    output logic edge_stb
);

    lvl_e state_q;
    lvl_e state_d;
    logic clk_q;
    logic stb_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LVL_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LO: if (fire) state_d = LVL_HI;
            LVL_HI: if (fire) state_d = LVL_LO;
        endcase
    end

    // Outputs: present the held level, then the state flips
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= fire;
            if (fire) begin
                clk_q <= (state_q == LVL_HI);
            end
        end
    end

    assign ser_clk  = clk_q;
    assign edge_stb = stb_q;

endmodule

// File: rtl/tap_serial_clkgen.sv
module tap_serial_clkgen #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             ser_clk,
    output logic             edge_stb
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             tap_hit;
    logic             fire;

    tap_ref_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv    (ref_tick),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx)
    );

    tap_transition_sel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sel (
        .cur (cnt_q),
        .nxt (cnt_nx),
        .sel (rate_sel),
        .hit (tap_hit)
    );

    assign fire = ref_tick & tap_hit;

    tap_level_fsm u_lvl (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .ser_clk  (ser_clk),
        .edge_stb (edge_stb)
    );

endmodule

// File: rtl/tap_clkgen_checker.sv
module tap_clkgen_checker #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_tick,
    input logic [SEL_W-1:0] rate_sel,
    input logic             ser_clk,
    input logic             edge_stb,
    input logic [CNT_W-1:0] cnt_q
);

    assert_idle_no_event_R2: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> !edge_stb);

    assert_bit0_every_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && rate_sel[0]) |=> edge_stb);

    assert_clk_moves_only_on_event_R4: assert property (@(posedge clk) disable iff (rst)
        !edge_stb |-> $stable(ser_clk));

    assert_strobe_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
        edge_stb |-> $past(ref_tick));

    assert_top_tap_R6: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && rate_sel[SEL_W-1] && (cnt_q[SEL_W-2:0] == {(SEL_W-1){1'b1}})) |=> edge_stb);

    assert_wrap_fires_R8: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && (cnt_q == {CNT_W{1'b1}}) && (rate_sel != '0)) |=> edge_stb);

    assert_zero_sel_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && (rate_sel == '0)) |=> !edge_stb);

endmodule

bind tap_serial_clkgen tap_clkgen_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .rate_sel (rate_sel),
    .ser_clk  (ser_clk),
    .edge_stb (edge_stb),
    .cnt_q    (cnt_q)
);

// File: tb/test_tap_serial_clkgen.sv
`timescale 1ns/1ps
module test_tap_serial_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic [6:0] rate_sel = 7'h01;
    logic       ser_clk;
    logic       edge_stb;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench model state
    int  m_cnt = 0;
    bit  m_lvl = 1'b0;
    bit  m_clk = 1'b0;
    bit  m_stb = 1'b0;
    int  m_events = 0;

    always #2.5 clk = ~clk;

    tap_serial_clkgen i_tap_serial_clkgen (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .rate_sel (rate_sel),
        .ser_clk  (ser_clk),
        .edge_stb (edge_stb)
    );

    task automatic check(input string tag, input bit act, input bit exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0b (cnt=%0d sel=%02h)",
                     tag, what, act, exp, m_cnt, rate_sel);
        end
    endtask

    // Drive at negedge, register at posedge, sample 1 ns later.
    task automatic apply(input bit tk, input logic [6:0] sel, input string tag);
        bit    hit;
        bit    wrap;
        string use_tag;
        ref_tick = tk;
        rate_sel = sel;
        @(posedge clk);
        #1;
        hit  = 1'b0;
        wrap = 1'b0;
        if (tk) begin
            for (int b = 0; b < 7; b++) begin
                if (sel[b] && (((m_cnt + 1) % (1 << b)) == 0)) hit = 1'b1;
            end
            wrap  = (m_cnt == 255);
            m_cnt = (m_cnt + 1) % 256;
        end
        if (hit) begin
            m_clk = m_lvl;
            m_lvl = !m_lvl;
            m_stb = 1'b1;
            m_events++;
        end else begin
            m_stb = 1'b0;
        end
        use_tag = (wrap && sel != 0) ? "R8" : tag;
        check(use_tag, edge_stb, m_stb, "edge_stb");
        check((hit ? "R4" : use_tag), ser_clk, m_clk, "ser_clk");
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ref_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_cnt = 0; m_lvl = 1'b0; m_clk = 1'b0; m_stb = 1'b0;
        check("R1", ser_clk, 1'b0, "ser_clk in reset");
        check("R1", edge_stb, 1'b0, "edge_stb in reset");
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int ev_before;
        @(negedge clk);
        do_reset();

        // R1: counter cleared -> with tap 2 the first event comes on strobe 4
        for (int k = 0; k < 4; k++) apply(1'b1, 7'h04, "R1");
        check("R1", bit'(m_events == 1), 1'b1, "first event after 4 strobes");

        // R3 / R6: every single tap across more than one wrap, strobe every cycle
        for (int b = 0; b < 7; b++) begin
            do_reset();
            ev_before = m_events;
            for (int k = 0; k < 512; k++) apply(1'b1, 7'(1 << b), (b == 6) ? "R6" : "R3");
            check((b == 6) ? "R6" : "R3", bit'((m_events - ev_before) == (512 >> b)), 1'b1,
                  "event count per tap");
        end

        // R2: sparse strobes with idle cycles in between
        for (int b = 0; b < 7; b += 2) begin
            do_reset();
            for (int k = 0; k < 300; k++) begin
                apply(1'b1, 7'(1 << b), "R3");
                apply(1'b0, 7'(1 << b), "R2");
                if (k % 3 == 0) apply(1'b0, 7'h7F, "R2");
            end
        end

        // R7: several taps together, including all seven across wraps
        begin
            logic [6:0] combos [4] = '{7'h05, 7'h41, 7'h7F, 7'h2A};
            for (int c = 0; c < 4; c++) begin
                do_reset();
                for (int k = 0; k < 520; k++) apply(1'b1, combos[c], "R7");
            end
        end

        // R10: zero select, counter still advances (seen when tap comes back)
        do_reset();
        ev_before = m_events;
        for (int k = 0; k < 300; k++) apply(1'b1, 7'h00, "R10");
        check("R10", bit'(m_events == ev_before), 1'b1, "no events with zero select");
        for (int k = 0; k < 40; k++) apply(1'b1, 7'h10, "R10");

        // R9: select changes every strobe, including on the strobe before a wrap
        do_reset();
        for (int k = 0; k < 1024; k++) begin
            apply(1'b1, 7'((k * 37 + (k >> 3)) % 128), "R9");
        end
        for (int k = 0; k < 600; k++) begin
            apply(1'b1, (m_cnt == 255) ? 7'h40 : 7'h00, "R9");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule